// File: doc/BRIEF.md
# SPI Flash Access Sequencer

This block converts a single memory-style access aimed at one flash chip select into the byte sequence a serial flash expects. A request carries a byte offset, a length of one to four bytes, write data, a direction and the chip-select index. The control word of that chip select sets the transfer style. In the three framed styles (plain read, fast read, program write) the block drives the chip select low. It then sends an opcode, the offset most significant byte first, an optional run of dummy bytes, and the data. After that it releases the chip select. In passthrough style, bytes go straight between the access and the serial shifter, and the chip select follows a software-owned bit.

The serial shifter sits outside the block and is reached through a byte handshake. The block raises `spi_req` with a byte on `spi_tx` and holds both until `spi_done` returns the byte clocked in on `spi_rx`. Read bytes are packed little-endian into `rdata`. A request that the control settings do not allow finishes at once, with `err` set and no serial traffic.

Top module: `sflash_seq`

## Requirements
- R1: After reset `busy`, `done` and `spi_req` are low, and every chip select whose control word is not in passthrough style is high.
- R2: Control bits [1:0] select the style: 0 plain read, 1 fast read, 2 program write, 3 passthrough. In plain read the opcode sent is always 0x03, whatever bits [23:16] hold. The opcode is followed by three offset bytes and then the data bytes, with no dummy bytes even if the dummy bits are nonzero.
- R3: When the chip select's wide-address input is set, the framed styles send four offset bytes instead of three, most significant first.
- R4: In fast read the opcode is control bits [23:16]. The offset is followed by D dummy bytes, where D = 8 × ({bit 14, bits 7:6} read as a 3-bit number), and each dummy byte equals `cfg_dummy_data`.
- R5: When control bit 28 is set, the fast-read dummy count D is halved.
- R6: In program write the opcode is bits [23:16]. The offset follows, then the data bytes, with data byte i taken from `req_wdata[8i+7:8i]`.
- R7: A read moves `req_len_m1`+1 data bytes, and data byte i lands in `rdata[8i+7:8i]`; the other `rdata` bytes read zero. After a write or a rejected request, `rdata` is zero.
- R8: In the framed styles the selected `cs_n` bit is low for every byte of the sequence, all other bits stay high, and it is high again in the cycle that `done` pulses.
- R9: In passthrough style no opcode, offset or dummy is sent. A read sends 0x00 per data byte and a write sends the data bytes. The chip select of that index equals its control bit 2 throughout.
- R10: A write to a chip select whose `cfg_wr_en` bit is clear, in any style, completes with `err` high and no byte request.
- R11: A read in program-write style, and a write in plain- or fast-read style, complete with `err` high and no byte request.
- R12: Only one byte request is open at a time, and `spi_req` and `spi_tx` hold until `spi_done`. `busy` stays high from the cycle after acceptance until `done` has pulsed for one cycle. A request with N bytes served after a fixed gap therefore takes a predictable number of cycles, and a rejected one finishes in the first cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request, taken when `busy` is low |
| req_write | input | 1 | 1 for write, 0 for read |
| req_cs | input | CS_W | Chip-select index |
| req_addr | input | 32 | Byte offset inside the segment |
| req_len_m1 | input | 2 | Byte count minus one |
| req_wdata | input | 32 | Write data, byte 0 in bits [7:0] |
| cfg_ctrl | input | NUM_CS*32 | Control word per chip select, index i in bits [32i+31:32i] |
| cfg_wr_en | input | NUM_CS | Write permission per chip select |
| cfg_wide_addr | input | NUM_CS | Four-byte offset per chip select |
| cfg_dummy_data | input | 8 | Byte sent for each dummy slot |
| spi_req | output | 1 | Byte request to the shifter |
| spi_tx | output | 8 | Byte to shift out |
| spi_done | input | 1 | Shifter finished the current byte |
| spi_rx | input | 8 | Byte shifted in, valid with `spi_done` |
| cs_n | output | NUM_CS | Active-low chip selects |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last request was rejected, valid with `done` |
| rdata | output | 32 | Read data, little-endian |

## Verification
The hardest cases to reach are the long fast-read dummy runs, because the count comes from three scattered control bits and a halving bit. The bench sweeps all eight dummy codes with the halving bit both clear and set, and predicts every byte of the stream, up to 56 dummy bytes. Each request is also served with a varying gap before `spi_done`. This shows the held request and the cycle count from acceptance to the completion pulse, which a rejected request must reach in the first cycle.

// File: rtl/sflash_pkg.sv
package sflash_pkg;

  localparam int CTRL_W      = 32;
  localparam int DUMMY_CNT_W = 6;

  // control word field positions
  localparam int BIT_STOP    = 2;
  localparam int BIT_DLO     = 6;
  localparam int BIT_DHI     = 14;
  localparam int BIT_OP      = 16;
  localparam int BIT_HALVE   = 28;

  localparam logic [7:0] PLAIN_READ_OP = 8'h03;

  typedef enum logic [1:0] {
    MODE_READ  = 2'd0,
    MODE_FAST  = 2'd1,
    MODE_WRITE = 2'd2,
    MODE_USER  = 2'd3
  } xfer_mode_e;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_CMD,
    PH_ADDR,
    PH_DUMMY,
    PH_DATA,
    PH_FIN
  } phase_e;

  typedef struct packed {
    logic                   framed;
    logic                   reject;
    logic [7:0]             opcode;
    logic                   wide_addr;
    logic [DUMMY_CNT_W-1:0] n_dummy;
  } xfer_plan_t;

endpackage

// File: rtl/sflash_decode.sv
module sflash_decode
  import sflash_pkg::*;
(
  input  logic [CTRL_W-1:0] ctrl_word,
  input  logic              write_req,
  input  logic              wr_allow,
  input  logic              wide_addr,
  output xfer_plan_t        plan
);

  xfer_mode_e mode;
  logic [2:0] dsel;
  logic       unused_bits;

  assign unused_bits = ^{ctrl_word[31:29], ctrl_word[27:24], ctrl_word[15],
                         ctrl_word[13:8], ctrl_word[5:2]};

  always_comb begin
    mode = xfer_mode_e'(ctrl_word[1:0]);
    dsel = {ctrl_word[BIT_DHI], ctrl_word[BIT_DLO+1], ctrl_word[BIT_DLO]};

    plan.framed    = (mode != MODE_USER);
    plan.opcode    = (mode == MODE_READ) ? PLAIN_READ_OP : ctrl_word[BIT_OP +: 8];
    plan.wide_addr = wide_addr;

    if (mode == MODE_FAST) begin
      plan.n_dummy = ctrl_word[BIT_HALVE] ? {1'b0, dsel, 2'b00} : {dsel, 3'b000};
    end else begin
      plan.n_dummy = '0;
    end

    if (write_req) begin
      plan.reject = !wr_allow || !((mode == MODE_WRITE) || (mode == MODE_USER));
    end else begin
      plan.reject = (mode == MODE_WRITE);
    end
  end

endmodule

// File: rtl/sflash_csdrv.sv
module sflash_csdrv
  import sflash_pkg::*;
#(
  parameter int NUM_CS = 2,
  parameter int CS_W   = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic [NUM_CS*CTRL_W-1:0] ctrl_all,
  input  logic                     sel_active,
  input  logic [CS_W-1:0]          sel_cs,
  output logic [NUM_CS-1:0]        cs_n
);

  for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
    logic [CTRL_W-1:0] word;
    logic              is_user;
    logic              framed_sel;
    logic              unused_word;

    assign word        = ctrl_all[i*CTRL_W +: CTRL_W];
    assign unused_word = ^{word[CTRL_W-1:3]};
    assign is_user     = (xfer_mode_e'(word[1:0]) == MODE_USER);
    assign framed_sel  = sel_active && (sel_cs == CS_W'(i));
    assign cs_n[i]     = !framed_sel && (is_user ? word[BIT_STOP] : 1'b1);
  end

endmodule

// File: rtl/sflash_fsm.sv
module sflash_fsm
  import sflash_pkg::*;
#(
  parameter int CS_W = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic            req_write,
  input  logic [CS_W-1:0] req_cs,
  input  logic [31:0]     req_addr,
  input  logic [1:0]      req_len_m1,
  input  logic [31:0]     req_wdata,
  input  xfer_plan_t      plan_in,
  input  logic [7:0]      dummy_byte,
  input  logic            spi_done,
  input  logic [7:0]      spi_rx,
  output logic            spi_req,
  output logic [7:0]      spi_tx,
  output logic            busy,
  output logic            done,
  output logic            err,
  output logic [31:0]     rdata,
  output logic            sel_active,
  output logic [CS_W-1:0] sel_cs
);

  phase_e                 ph_q, ph_d;
  logic [DUMMY_CNT_W-1:0] cnt_q, cnt_d;
  xfer_plan_t             plan_q;
  logic [31:0]            addr_q, wdata_q;
  logic [1:0]             len_q;
  logic                   wr_q;
  logic [CS_W-1:0]        cs_q;
  logic [31:0]            rdata_q, rdata_d;
  logic                   err_q, err_d;
  logic                   load, step;
  logic [DUMMY_CNT_W-1:0] last_addr;
  logic [1:0]             aidx;

  assign load      = (ph_q == PH_IDLE) && req_valid;
  assign spi_req   = (ph_q == PH_CMD) || (ph_q == PH_ADDR) ||
                     (ph_q == PH_DUMMY) || (ph_q == PH_DATA);
  assign step      = spi_req && spi_done;
  assign last_addr = plan_q.wide_addr ? DUMMY_CNT_W'(3) : DUMMY_CNT_W'(2);
  assign aidx      = (plan_q.wide_addr ? 2'd3 : 2'd2) - cnt_q[1:0];

  // next state
  always_comb begin
    ph_d    = ph_q;
    cnt_d   = cnt_q;
    rdata_d = rdata_q;
    err_d   = err_q;
    unique case (ph_q)
      PH_IDLE: begin
        if (req_valid) begin
          cnt_d   = '0;
          rdata_d = '0;
          err_d   = plan_in.reject;
          if (plan_in.reject)      ph_d = PH_FIN;
          else if (plan_in.framed) ph_d = PH_CMD;
          else                     ph_d = PH_DATA;
        end
      end
      PH_CMD: begin
        if (step) begin
          ph_d  = PH_ADDR;
          cnt_d = '0;
        end
      end
      PH_ADDR: begin
        if (step) begin
          if (cnt_q == last_addr) begin
            cnt_d = '0;
            ph_d  = (plan_q.n_dummy != '0) ? PH_DUMMY : PH_DATA;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      PH_DUMMY: begin
        if (step) begin
          if (cnt_q == plan_q.n_dummy - 1'b1) begin
            cnt_d = '0;
            ph_d  = PH_DATA;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      PH_DATA: begin
        if (step) begin
          if (!wr_q) rdata_d[{cnt_q[1:0], 3'b000} +: 8] = spi_rx;
          if (cnt_q[1:0] == len_q) ph_d = PH_FIN;
          else                     cnt_d = cnt_q + 1'b1;
        end
      end
      PH_FIN:  ph_d = PH_IDLE;
      default: ph_d = PH_IDLE;
    endcase
  end

  // byte presented to the shifter
  always_comb begin
    unique case (ph_q)
      PH_CMD:   spi_tx = plan_q.opcode;
      PH_ADDR:  spi_tx = addr_q[{aidx, 3'b000} +: 8];
      PH_DUMMY: spi_tx = dummy_byte;
      PH_DATA:  spi_tx = wr_q ? wdata_q[{cnt_q[1:0], 3'b000} +: 8] : 8'h00;
      default:  spi_tx = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q    <= PH_IDLE;
      cnt_q   <= '0;
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      ph_q    <= ph_d;
      cnt_q   <= cnt_d;
      rdata_q <= rdata_d;
      err_q   <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      plan_q  <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      len_q   <= '0;
      wr_q    <= 1'b0;
      cs_q    <= '0;
    end else if (load) begin
      plan_q  <= plan_in;
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      len_q   <= req_len_m1;
      wr_q    <= req_write;
      cs_q    <= req_cs;
    end
  end

  assign busy       = (ph_q != PH_IDLE);
  assign done       = (ph_q == PH_FIN);
  assign err        = err_q;
  assign rdata      = rdata_q;
  assign sel_active = spi_req && plan_q.framed;
  assign sel_cs     = cs_q;

endmodule

// File: rtl/sflash_seq.sv
module sflash_seq
  import sflash_pkg::*;
#(
  parameter int NUM_CS = 2,
  parameter int CS_W   = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  input  logic                     req_write,
  input  logic [CS_W-1:0]          req_cs,
  input  logic [31:0]              req_addr,
  input  logic [1:0]               req_len_m1,
  input  logic [31:0]              req_wdata,
  input  logic [NUM_CS*CTRL_W-1:0] cfg_ctrl,
  input  logic [NUM_CS-1:0]        cfg_wr_en,
  input  logic [NUM_CS-1:0]        cfg_wide_addr,
  input  logic [7:0]               cfg_dummy_data,
  output logic                     spi_req,
  output logic [7:0]               spi_tx,
  input  logic                     spi_done,
  input  logic [7:0]               spi_rx,
  output logic [NUM_CS-1:0]        cs_n,
  output logic                     busy,
  output logic                     done,
  output logic                     err,
  output logic [31:0]              rdata
);

  logic [CTRL_W-1:0] ctrl_sel;
  xfer_plan_t        plan;
  logic              sel_active;
  logic [CS_W-1:0]   sel_cs;

  assign ctrl_sel = cfg_ctrl[int'(req_cs)*CTRL_W +: CTRL_W];

  sflash_decode u_dec (
    .ctrl_word (ctrl_sel),
    .write_req (req_write),
    .wr_allow  (cfg_wr_en[req_cs]),
    .wide_addr (cfg_wide_addr[req_cs]),
    .plan      (plan)
  );

  sflash_fsm #(.CS_W(CS_W)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_cs     (req_cs),
    .req_addr   (req_addr),
    .req_len_m1 (req_len_m1),
    .req_wdata  (req_wdata),
    .plan_in    (plan),
    .dummy_byte (cfg_dummy_data),
    .spi_done   (spi_done),
    .spi_rx     (spi_rx),
    .spi_req    (spi_req),
    .spi_tx     (spi_tx),
    .busy       (busy),
    .done       (done),
    .err        (err),
    .rdata      (rdata),
    .sel_active (sel_active),
    .sel_cs     (sel_cs)
  );

  sflash_csdrv #(.NUM_CS(NUM_CS), .CS_W(CS_W)) u_cs (
    .ctrl_all   (cfg_ctrl),
    .sel_active (sel_active),
    .sel_cs     (sel_cs),
    .cs_n       (cs_n)
  );

endmodule

// File: rtl/sflash_seq_chk.sv
module sflash_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       busy,
  input logic       done,
  input logic       err,
  input logic       spi_req,
  input logic       spi_done,
  input logic [7:0] spi_tx
);

  // R12: byte requests only inside a transaction
  assert_req_in_txn_R12: assert property (@(posedge clk) disable iff (!rst_n)
    spi_req |-> busy);

  // R12: an open byte request holds its byte until served
  assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_req && !spi_done) |=> (spi_req && $stable(spi_tx)));

  // R12: completion is a single pulse and the block goes idle after it
  assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  // R10 / R11: a rejected request finishes right after acceptance
  assert_reject_fast_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err) |-> ($past(req_valid) && !$past(busy)));

endmodule

bind sflash_seq sflash_seq_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_valid(req_valid),
  .busy     (busy),
  .done     (done),
  .err      (err),
  .spi_req  (spi_req),
  .spi_done (spi_done),
  .spi_tx   (spi_tx)
);

// File: tb/sim_sflash_seq.sv
module sim_sflash_seq;

  localparam int CLK_PERIOD = 10;
  localparam int NUM_CS     = 2;
  localparam int CS_W       = 1;

  logic                 clk, rst_n;
  logic                 req_valid, req_write;
  logic [CS_W-1:0]      req_cs;
  logic [31:0]          req_addr, req_wdata;
  logic [1:0]           req_len_m1;
  logic [NUM_CS*32-1:0] cfg_ctrl;
  logic [NUM_CS-1:0]    cfg_wr_en, cfg_wide_addr;
  logic [7:0]           cfg_dummy_data;
  logic                 spi_req, spi_done;
  logic [7:0]           spi_tx, spi_rx;
  logic [NUM_CS-1:0]    cs_n;
  logic                 busy, done, err;
  logic [31:0]          rdata;

  int n_tests = 0;
  int n_fail  = 0;

  // responder state
  int        gap = 0;
  int        gap_cnt = 0;
  int        nlog = 0;
  logic [7:0]        log_tx [0:127];
  logic [NUM_CS-1:0] log_cs [0:127];

  sflash_seq #(.NUM_CS(NUM_CS)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_cs(req_cs), .req_addr(req_addr), .req_len_m1(req_len_m1),
    .req_wdata(req_wdata), .cfg_ctrl(cfg_ctrl), .cfg_wr_en(cfg_wr_en),
    .cfg_wide_addr(cfg_wide_addr), .cfg_dummy_data(cfg_dummy_data),
    .spi_req(spi_req), .spi_tx(spi_tx), .spi_done(spi_done), .spi_rx(spi_rx),
    .cs_n(cs_n), .busy(busy), .done(done), .err(err), .rdata(rdata)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] rx_pat(int j);
    return 8'(8'h31 + j * 7);
  endfunction

  function automatic logic [31:0] mk_ctrl(logic [1:0] mode, logic [7:0] op,
                                          logic [2:0] dcode, logic halve, logic stop);
    logic [31:0] c;
    c = '0;
    c[1:0]   = mode;
    c[2]     = stop;
    c[7:6]   = dcode[1:0];
    c[14]    = dcode[2];
    c[23:16] = op;
    c[28]    = halve;
    return c;
  endfunction

  // serial shifter model
  initial begin
    spi_done = 1'b0;
    spi_rx   = 8'h00;
    forever begin
      @(negedge clk);
      if (spi_done) begin
        spi_done = 1'b0;
      end else if (spi_req) begin
        if (gap_cnt < gap) begin
          gap_cnt++;
        end else begin
          if (nlog < 128) begin
            log_tx[nlog] = spi_tx;
            log_cs[nlog] = cs_n;
          end
          spi_rx   = rx_pat(nlog);
          nlog++;
          spi_done = 1'b1;
          gap_cnt  = 0;
        end
      end
    end
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic run(input logic [1:0] mode, input logic [7:0] op,
                     input logic [2:0] dcode, input logic halve, input logic stop,
                     input logic wren, input logic wide, input int cs,
                     input logic wr, input logic [31:0] addr, input logic [1:0] len,
                     input logic [31:0] wdata, input string tag);
    logic [7:0]        expb [0:127];
    int                n, nab, nd, cyc, start, explat;
    bit                reject, ok, busy_ok, cs_ok;
    logic [31:0]       exp_rd;
    logic [NUM_CS-1:0] exp_cs, exp_cs_done;

    reject = wr ? (!wren || (mode != 2'd2 && mode != 2'd3)) : (mode == 2'd2);
    n = 0;
    if (!reject) begin
      if (mode != 2'd3) begin
        expb[n] = (mode == 2'd0) ? 8'h03 : op; n++;
        nab = wide ? 4 : 3;
        for (int k = 0; k < nab; k++) begin
          expb[n] = 8'(addr >> (8 * (nab - 1 - k))); n++;
        end
        if (mode == 2'd1) begin
          nd = int'(dcode) * 8;
          if (halve) nd = nd / 2;
          for (int k = 0; k < nd; k++) begin
            expb[n] = cfg_dummy_data; n++;
          end
        end
      end
      for (int i = 0; i <= int'(len); i++) begin
        expb[n] = wr ? 8'(wdata >> (8 * i)) : 8'h00; n++;
      end
    end
    exp_rd = '0;
    if (!reject && !wr) begin
      start = n - (int'(len) + 1);
      for (int i = 0; i <= int'(len); i++) exp_rd[8*i +: 8] = rx_pat(start + i);
    end
    exp_cs      = '1;
    exp_cs_done = '1;
    if (mode != 2'd3 || !stop) exp_cs[cs] = 1'b0;
    if (mode == 2'd3 && !stop) exp_cs_done[cs] = 1'b0;
    explat = reject ? 0 : n * (gap + 2) - 1;

    @(negedge clk);
    for (int c = 0; c < NUM_CS; c++)
      cfg_ctrl[c*32 +: 32] = mk_ctrl(2'd0, 8'h00, 3'd0, 1'b0, 1'b1);
    cfg_ctrl[cs*32 +: 32] = mk_ctrl(mode, op, dcode, halve, stop);
    cfg_wr_en            = '0;
    cfg_wr_en[cs]        = wren;
    cfg_wide_addr        = '0;
    cfg_wide_addr[cs]    = wide;
    req_cs     = CS_W'(cs);
    req_write  = wr;
    req_addr   = addr;
    req_len_m1 = len;
    req_wdata  = wdata;
    req_valid  = 1'b1;
    nlog       = 0;
    gap_cnt    = 0;
    @(negedge clk);
    req_valid = 1'b0;
    cyc = 0;
    busy_ok = 1'b1;
    while (!done && cyc < 2000) begin
      if (!busy) busy_ok = 1'b0;
      @(negedge clk);
      cyc++;
    end

    ok = (nlog == n);
    for (int k = 0; k < n && k < 128; k++) if (log_tx[k] !== expb[k]) ok = 1'b0;
    check(ok, tag, "byte stream (count)", 64'(nlog), 64'(n));
    cs_ok = 1'b1;
    for (int k = 0; k < nlog && k < 128; k++) if (log_cs[k] !== exp_cs) cs_ok = 1'b0;
    check(cs_ok, (mode == 2'd3) ? "R9" : "R8", "chip select during bytes",
          64'(nlog > 0 ? log_cs[0] : cs_n), 64'(exp_cs));
    check(cs_n === exp_cs_done, (mode == 2'd3) ? "R9" : "R8", "chip select at done",
          64'(cs_n), 64'(exp_cs_done));
    check(rdata === exp_rd, "R7", "read data", 64'(rdata), 64'(exp_rd));
    check(err === reject, reject ? tag : "R11", "error flag", 64'(err), 64'(reject));
    check(busy_ok && done && cyc == explat, "R12", "cycles to done",
          64'(cyc), 64'(explat));
  endtask

  // watchdog
  initial begin
    #(CLK_PERIOD * 150000);
    n_tests++;
    n_fail++;
    $display("FAIL R12 watchdog expired: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0; req_write = 1'b0; req_cs = '0; req_addr = '0;
    req_len_m1 = '0; req_wdata = '0;
    cfg_ctrl = {NUM_CS{mk_ctrl(2'd0, 8'h00, 3'd0, 1'b0, 1'b1)}};
    cfg_wr_en = '0; cfg_wide_addr = '0; cfg_dummy_data = 8'hC7;
    repeat (3) @(negedge clk);
    check(!busy && !done && !spi_req, "R1", "idle outputs in reset",
          64'({busy, done, spi_req}), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !done && !spi_req, "R1", "idle outputs after reset",
          64'({busy, done, spi_req}), 64'd0);
    check(cs_n === '1, "R1", "chip selects after reset", 64'(cs_n), 64'h3);

    // plain read: opcode forced, dummy bits ignored, 3 or 4 offset bytes
    for (int cs = 0; cs < 2; cs++)
      for (int w = 0; w < 2; w++)
        for (int l = 0; l < 4; l++) begin
          gap = (cs + l) % 3;
          run(2'd0, 8'hAB, 3'd5, 1'b0, 1'b1, 1'b0, w[0], cs, 1'b0,
              32'h1234_5678 + 32'(l * 32'h0101_0101), l[1:0], 32'h0, w ? "R3" : "R2");
        end

    // fast read: all dummy codes, halving on and off
    for (int d = 0; d < 8; d++)
      for (int h = 0; h < 2; h++) begin
        gap = (d + h) % 3;
        cfg_dummy_data = 8'(8'h90 + d);
        run(2'd1, 8'h0B, d[2:0], h[0], 1'b1, 1'b0, d[0], h, 1'b0,
            32'hA5C3_0F1E ^ 32'(d << 8), 2'(d), 32'h0, h ? "R5" : "R4");
      end

    // program write
    for (int cs = 0; cs < 2; cs++)
      for (int l = 0; l < 4; l++) begin
        gap = l % 3;
        run(2'd2, 8'h02, 3'd7, 1'b0, 1'b1, 1'b1, cs[0], cs, 1'b1,
            32'h00_3E_7C_01, l[1:0], 32'hDEAD_BEEF ^ 32'(l * 32'h1111_1111), "R6");
      end

    // passthrough reads and writes, chip select from the stop bit
    for (int s = 0; s < 2; s++)
      for (int wr = 0; wr < 2; wr++)
        for (int l = 0; l < 4; l++) begin
          gap = (s + wr + l) % 3;
          run(2'd3, 8'h9F, 3'd3, 1'b1, s[0], 1'b1, 1'b1, (s + l) % 2, wr[0],
              32'hFFFF_FFFF, l[1:0], 32'h0BAD_F00D + 32'(l), "R9");
        end

    // writes without permission, framed and passthrough
    gap = 1;
    run(2'd2, 8'h02, 3'd0, 1'b0, 1'b1, 1'b0, 1'b0, 0, 1'b1, 32'h10, 2'd3, 32'h1, "R10");
    run(2'd3, 8'h00, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1, 1'b1, 32'h20, 2'd0, 32'h2, "R10");

    // style / direction mismatches
    run(2'd2, 8'h02, 3'd0, 1'b0, 1'b1, 1'b1, 1'b0, 0, 1'b0, 32'h30, 2'd1, 32'h0, "R11");
    run(2'd0, 8'h02, 3'd0, 1'b0, 1'b1, 1'b1, 1'b0, 1, 1'b1, 32'h40, 2'd1, 32'h3, "R11");
    run(2'd1, 8'h0B, 3'd2, 1'b0, 1'b1, 1'b1, 1'b1, 0, 1'b1, 32'h50, 2'd2, 32'h4, "R11");

    // recovery after a rejection
    gap = 2;
    run(2'd1, 8'h3B, 3'd1, 1'b1, 1'b1, 1'b0, 1'b1, 1, 1'b0, 32'h7654_3210, 2'd3, 32'h0, "R12");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule